// File: doc/BRIEF.md
# Data-Strobe Receive Deserializer

This block takes the data and strobe lines of one cable port, already sampled by a fast sample clock, and recovers the serial bit stream from them. A new bit is present whenever the exclusive-OR of data and strobe changes level. The bit's value is the data level at that moment. The recovered bits are packed into parallel words. A word is 2 bits wide at the lower speed and 4 bits wide at the higher speed, and the first bit received sits in the most significant position.

Each completed word is written into a small dual-clock FIFO. The FIFO's pointers cross between domains in Gray code. On the link clock side, the FIFO presents the word together with a one-cycle valid flag. A receive enable gates the whole path. While the port is receiving, the block also tells the port's transmitters to stay off.

Top module: `ds_rx_deser`

## Requirements
- R1: A bit is captured in each sample-clock cycle in which data XOR strobe differs from its value one cycle earlier, and the captured value is the data level; no bit is captured while that XOR is unchanged.
- R2: With speed_i=1, every 4 captured bits form one word; the first bit of the group appears on word_o[3] and the last on word_o[0].
- R3: With speed_i=0, every 2 captured bits form one word; the first bit appears on word_o[1], the second on word_o[0], and word_o[3:2] are 0.
- R4: While rx_en_i=0, no bit is captured and no word is produced, and the bit count returns to zero. Bits of an unfinished word received before rx_en_i fell are dropped.
- R5: Words reach the link domain in the order they were formed. Each word is shown for exactly one link_clk_i cycle with word_vld_o=1.
- R6: tx_dis_o equals rx_en_i at all times, so the port's transmitters are off while it receives.
- R7: After rst_ni is asserted low, word_o is 0 and word_vld_o is 0.
- R8: A change of speed_i while receiving drops any unfinished word, and counting restarts from the next captured bit.
- R9: The write pointer that crosses into the link domain changes by at most one bit per sample-clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| samp_clk_i | input | 1 | Sample clock for the data and strobe lines |
| link_clk_i | input | 1 | Link-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| rx_en_i | input | 1 | Port receive enable (sample domain) |
| speed_i | input | 1 | 0: 2-bit words, 1: 4-bit words (sample domain) |
| data_i | input | 1 | Sampled data line |
| strobe_i | input | 1 | Sampled strobe line |
| tx_dis_o | output | 1 | Transmitter disable for this port |
| word_o | output | 4 | Parallel received word (link domain) |
| word_vld_o | output | 1 | Word valid, one link cycle per word |

## Verification
The bench sends patterns with runs of equal bits, because that is when the strobe toggles instead of the data. A recovery stage that watched only the data line would then lose bits and shift every later word. Both word widths are checked for bit order. A design that reversed the order would show mirrored nibbles or pairs, and a wrong 2-bit packing would leave stale high bits. The bench also drops the enable in the middle of a word and changes the speed in the middle of a word. A design that kept the partial count would emit a word made of old and new bits. While the enable is low, the bench sends bits and expects no output at all.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  localparam int unsigned W_WIDE   = 4;
  localparam int unsigned W_NARROW = 2;
  localparam int unsigned CNT_W    = $clog2(W_WIDE);
  typedef logic [W_WIDE-1:0] word_t;
endpackage

// File: rtl/ds_edge_detect.sv
module ds_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic strobe_i,
  output logic bit_evt_o,
  output logic bit_o
);
  logic d_q, s_q, x_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q      <= 1'b0;
      s_q      <= 1'b0;
      x_prev_q <= 1'b0;
    end else begin
      d_q      <= data_i;
      s_q      <= strobe_i;
      x_prev_q <= d_q ^ s_q;
    end
  end

  // any transition of data^strobe marks one bit period
  assign bit_evt_o = (d_q ^ s_q) != x_prev_q;
  assign bit_o     = d_q;
endmodule

// File: rtl/ds_deser.sv
module ds_deser
  import ds_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             speed_i,
  input  logic             bit_evt_i,
  input  logic             bit_i,
  output word_t            word_o,
  output logic             word_vld_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(W_WIDE - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(W_NARROW - 1);

  word_t            sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             speed_q;
  logic [CNT_W-1:0] last;
  word_t            next_word;

  assign last = speed_i ? LAST_WIDE : LAST_NARROW;

  always_comb begin
    if (speed_i) next_word = {sh_q[W_WIDE-2:0], bit_i};
    else         next_word = {{(W_WIDE-W_NARROW){1'b0}}, sh_q[W_NARROW-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      speed_q    <= 1'b0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      speed_q    <= speed_i;
      word_vld_o <= 1'b0;
      if (!rx_en_i || (speed_i != speed_q)) begin
        cnt_q <= '0;
      end else if (bit_evt_i) begin
        sh_q <= {sh_q[W_WIDE-2:0], bit_i};
        if (cnt_q == last) begin
          cnt_q      <= '0;
          word_o     <= next_word;
          word_vld_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ds_cdc_fifo.sv
module ds_cdc_fifo #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 4
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             rvld_o,
  output logic [$clog2(DEPTH):0] wgray_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [AW:0] rg_s1_q, rg_s2_q, wg_s1_q, wg_s2_q;
  logic [AW:0] wbin_nx, rbin_nx;
  logic full, empty;

  assign wbin_nx = wbin_q + 1'b1;
  assign rbin_nx = rbin_q + 1'b1;
  assign full  = wgray_q == {~rg_s2_q[AW:AW-1], rg_s2_q[AW-2:0]};
  assign empty = rgray_q == wg_s2_q;

  always_ff @(posedge wclk_i) begin
    if (wr_i && !full) mem_q[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rg_s1_q <= '0;
      rg_s2_q <= '0;
    end else begin
      rg_s1_q <= rgray_q;
      rg_s2_q <= rg_s1_q;
      if (wr_i && !full) begin
        wbin_q  <= wbin_nx;
        wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_s1_q <= '0;
      wg_s2_q <= '0;
      rdata_o <= '0;
      rvld_o  <= 1'b0;
    end else begin
      wg_s1_q <= wgray_q;
      wg_s2_q <= wg_s1_q;
      rvld_o  <= !empty;
      if (!empty) begin
        rdata_o <= mem_q[rbin_q[AW-1:0]];
        rbin_q  <= rbin_nx;
        rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end

  assign wgray_o = wgray_q;
endmodule

// File: rtl/ds_rx_deser.sv
module ds_rx_deser
  import ds_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              samp_clk_i,
  input  logic              link_clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              speed_i,
  input  logic              data_i,
  input  logic              strobe_i,
  output logic              tx_dis_o,
  output logic [W_WIDE-1:0] word_o,
  output logic              word_vld_o
);
  localparam int unsigned AW = $clog2(FIFO_DEPTH);

  logic             bit_evt, bit_val;
  word_t            wr_word;
  logic             wr_vld;
  logic [CNT_W-1:0] bit_cnt;
  logic [AW:0]      wr_gray;

  assign tx_dis_o = rx_en_i;

  ds_edge_detect u_edge (
    .clk_i    (samp_clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .strobe_i (strobe_i),
    .bit_evt_o(bit_evt),
    .bit_o    (bit_val)
  );

  ds_deser u_deser (
    .clk_i     (samp_clk_i),
    .rst_ni    (rst_ni),
    .rx_en_i   (rx_en_i),
    .speed_i   (speed_i),
    .bit_evt_i (bit_evt),
    .bit_i     (bit_val),
    .word_o    (wr_word),
    .word_vld_o(wr_vld),
    .cnt_o     (bit_cnt)
  );

  ds_cdc_fifo #(.WIDTH(W_WIDE), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk_i (samp_clk_i),
    .rclk_i (link_clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_vld),
    .wdata_i(wr_word),
    .rdata_o(word_o),
    .rvld_o (word_vld_o),
    .wgray_o(wr_gray)
  );
endmodule

// File: rtl/ds_rx_deser_chk.sv
module ds_rx_deser_chk
  import ds_rx_pkg::*;
#(
  parameter int unsigned AW = 2
) (
  input logic              samp_clk_i,
  input logic              link_clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              speed_i,
  input logic              wr_vld,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [AW:0]       wr_gray,
  input logic [W_WIDE-1:0] word_o,
  input logic              word_vld_o
);
  // R4
  no_word_when_off_chk: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !wr_vld);
  // R4
  cnt_clear_when_off_chk: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    !rx_en_i |=> bit_cnt == '0);
  // R8
  cnt_clear_on_speed_chk: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    (speed_i != $past(speed_i)) |=> bit_cnt == '0);
  // R3
  narrow_cnt_bound_chk: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    (!speed_i && !$past(speed_i)) |-> bit_cnt <= CNT_W'(W_NARROW - 1));
  // R9
  gray_one_step_chk: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
  // R7
  idle_out_zero_chk: assert property (@(posedge link_clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (!word_vld_o && word_o == '0));
endmodule

bind ds_rx_deser ds_rx_deser_chk #(.AW(AW)) u_chk (
  .samp_clk_i(samp_clk_i),
  .link_clk_i(link_clk_i),
  .rst_ni    (rst_ni),
  .rx_en_i   (rx_en_i),
  .speed_i   (speed_i),
  .wr_vld    (wr_vld),
  .bit_cnt   (bit_cnt),
  .wr_gray   (wr_gray),
  .word_o    (word_o),
  .word_vld_o(word_vld_o)
);

// File: tb/ds_rx_deser_test.sv
module ds_rx_deser_test;
  logic samp_clk = 1'b0, link_clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, speed = 1'b0, data = 1'b0, strobe = 1'b0;
  logic tx_dis, word_vld;
  logic [3:0] word;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [3:0] got_q[$];
  logic [3:0] exp_q[$];

  // {speed, 16-bit pattern, sent MSB first}
  localparam int NVEC = 6;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'hA5C3}, {1'b1, 16'h0000}, {1'b1, 16'hFF01},
    {1'b0, 16'h1E2D}, {1'b0, 16'hFFFF}, {1'b0, 16'h8001}
  };

  always #4  samp_clk = ~samp_clk;
  always #10 link_clk = ~link_clk;

  ds_rx_deser uut (
    .samp_clk_i(samp_clk), .link_clk_i(link_clk), .rst_ni(rst_n),
    .rx_en_i(rx_en), .speed_i(speed), .data_i(data), .strobe_i(strobe),
    .tx_dis_o(tx_dis), .word_o(word), .word_vld_o(word_vld)
  );

  always @(negedge link_clk) if (word_vld) got_q.push_back(word);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // data-strobe encode: strobe toggles only when data repeats
  task automatic send_bit(input logic b);
    @(negedge samp_clk);
    if (b == data) strobe = ~strobe;
    else data = b;
    repeat (2) @(negedge samp_clk);
  endtask

  task automatic drain_and_compare(input string req);
    repeat (30) @(negedge link_clk);
    chk({req, " count"}, got_q.size(), exp_q.size());
    while (exp_q.size() > 0 && got_q.size() > 0)
      chk({req, " word"}, got_q.pop_front(), exp_q.pop_front());
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge link_clk);
    // R7 reset state
    chk("R7 vld", word_vld, 0);
    chk("R7 word", word, 0);
    chk("R6 off", tx_dis, 0);
    @(negedge samp_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge samp_clk);

    // R4 disabled: bits ignored
    for (int i = 0; i < 8; i++) send_bit(i[0]);
    drain_and_compare("R4 disabled");

    rx_en = 1'b1;
    #1;
    chk("R6 on", tx_dis, 1);

    // R1 R2 R3 R5 table walk
    for (int v = 0; v < NVEC; v++) begin
      @(negedge samp_clk);
      speed = VEC[v][16];
      repeat (2) @(negedge samp_clk);
      for (int b = 15; b >= 0; b--) send_bit(VEC[v][b]);
      if (VEC[v][16]) for (int w = 3; w >= 0; w--) exp_q.push_back(VEC[v][w*4 +: 4]);
      else for (int w = 7; w >= 0; w--) exp_q.push_back({2'b00, VEC[v][w*2 +: 2]});
      drain_and_compare(VEC[v][16] ? "R2 R1 R5" : "R3 R1 R5");
    end

    // R4 partial word dropped on disable
    speed = 1'b1;
    repeat (2) @(negedge samp_clk);
    send_bit(1'b1);
    send_bit(1'b1);
    @(negedge samp_clk);
    rx_en = 1'b0;
    repeat (3) @(negedge samp_clk);
    rx_en = 1'b1;
    repeat (2) @(negedge samp_clk);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    exp_q.push_back(4'h6);
    drain_and_compare("R4 partial");

    // R8 speed change mid-word
    send_bit(1'b1); send_bit(1'b1);
    @(negedge samp_clk);
    speed = 1'b0;
    repeat (2) @(negedge samp_clk);
    send_bit(1'b0); send_bit(1'b1);
    exp_q.push_back(4'h1);
    drain_and_compare("R8 speed");

    // R1 idle lines: no change of data^strobe gives nothing
    repeat (40) @(negedge samp_clk);
    drain_and_compare("R1 idle");

    finish_run();
  end
endmodule